// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 40-bit physical address by walking four levels of mapping tables held in memory. A request carries the virtual address, an access kind (read, write or execute) and a flag saying whether the access comes from user or supervisor privilege. The walk begins at a root table whose 4 KB-aligned base comes from a register input. Each step reads one 64-bit entry over a request/response memory port. The entry supplies the base of the next table. At the last step it supplies the base of the page frame.

Before any memory traffic, the block checks that the address is in sign-extended (canonical) form. At every level it checks the entry's present flag, its reserved field and its permission flags. The walk stops at the first entry that fails a check and reports a fault code together with the level. A walk that succeeds returns the frame base joined to the page offset. Only one translation is in flight at a time. Requests that arrive while a walk is running are ignored.

Top module: `pt_walker`

## Requirements
- R1: An address whose bits 63:48 are not all equal to bit 47 is rejected with fault code 1 at level 0. No memory read is issued, and `done` is high in the cycle right after the request is accepted.
- R2: The walk reads exactly one entry per level, from top to bottom. The entry address is {table base[39:12], index, 3'b000}. The indices are taken from virtual address bits 47:39, 38:30, 29:21 and 20:12, in that order. The first table base is `root_base[39:12]`.
- R3: Each next table base comes from entry bits 39:12. A successful walk returns `paddr` = {page-table entry bits 39:12, virtual address bits 11:0} with `fault` low and `fault_code` 0.
- R4: An entry with bit 0 (present) clear ends the walk with fault code 2. `fault_level` is the step at which it happened: 0 is the top table and 3 is the page table. No further entries are read.
- R5: An entry with any nonzero bit in 51:40 ends the walk with fault code 3 at that level.
- R6: A write access (`req_acc` = 2'b01) to an entry with bit 1 (writable) clear ends the walk with fault code 4 at that level.
- R7: A user access (`req_user` = 1) to an entry with bit 2 (user) clear ends the walk with fault code 5 at that level.
- R8: An execute access (`req_acc` = 2'b10) while `nx_en` is 1, to an entry with bit 63 set, ends the walk with fault code 6 at that level. When `nx_en` is 0, bit 63 has no effect. Access kind 2'b00, and likewise 2'b11, is a read.
- R9: Within one entry, the checks rank not-present first, then reserved, then write, then user, then execute. The first failing level wins.
- R10: `req_ready` is high only when the block is idle. `mem_req_valid` is a one-cycle pulse. No new read is issued until `mem_rvalid` has returned the previous entry.
- R11: `done` is a one-cycle pulse, and `req_ready` returns high in the following cycle. A request that is presented while a walk is busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 40 | Root table base; bits 39:12 used |
| nx_en | input | 1 | Enables the execute-disable check |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| req_user | input | 1 | User privilege access |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 40 | Entry physical address |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 64 | Entry data |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation failed |
| fault_code | output | 3 | 1 non-canonical, 2 not present, 3 reserved, 4 write, 5 user, 6 execute |
| fault_level | output | 2 | Step at which the fault arose |
| paddr | output | 40 | Physical address |

## Verification
The bench builds random four-entry chains. Each entry has a biased chance of a clear present bit, a clear writable or user bit, a set execute-disable bit or a nonzero reserved field, and each chain is paired with random access kinds, privilege flags and `nx_en`. Comparing the result and the sequence of read addresses with a reference walk shows whether faults come from the right level and whether the walk stops where it should. Directed cases add upper-half canonical addresses and addresses that are non-canonical by a single bit. They also cover a missing entry at each level and entries that fail two checks at once, which separate the ranking of the checks. Requests presented in mid-walk with a different, non-canonical address would change the result if they were not ignored.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W  = 40,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_base,
  input  logic            nx_en,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic            req_user,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata,
  output logic            done,
  output logic            fault,
  output logic [2:0]      fault_code,
  output logic [1:0]      fault_level,
  output logic [PA_W-1:0] paddr
);
  localparam int FN_W   = PA_W - OFF_W;
  localparam int TOP_HI = OFF_W + 4 * IDX_W - 1;
  localparam int RSV_HI = 51;
  localparam int ENT_SH = 3;

  localparam logic [2:0] F_NONE = 3'd0, F_CANON = 3'd1, F_NP = 3'd2,
                         F_RSV = 3'd3, F_WR = 3'd4, F_USR = 3'd5, F_NX = 3'd6;
  localparam logic [1:0] A_WR = 2'b01, A_EX = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;
  st_t st;

  logic [63:0]      va_q;
  logic [1:0]       acc_q;
  logic             usr_q, nx_q;
  logic [1:0]       lvl;
  logic [FN_W-1:0]  base_q;
  logic [IDX_W-1:0] idx;
  logic [2:0]       chk;
  logic             in_canon;

  assign in_canon = (&req_vaddr[63:TOP_HI]) | ~(|req_vaddr[63:TOP_HI]);
  assign idx = va_q[OFF_W + (3 - int'(lvl)) * IDX_W +: IDX_W];

  always_comb begin
    if (!mem_rdata[0])                                     chk = F_NP;
    else if (|mem_rdata[RSV_HI:PA_W])                      chk = F_RSV;
    else if (acc_q == A_WR && !mem_rdata[1])               chk = F_WR;
    else if (usr_q && !mem_rdata[2])                       chk = F_USR;
    else if (acc_q == A_EX && nx_q && mem_rdata[63])       chk = F_NX;
    else                                                   chk = F_NONE;
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = {base_q, idx, {ENT_SH{1'b0}}};
  assign done          = (st == S_DONE);
  assign fault         = (fault_code != F_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lvl         <= '0;
      va_q        <= '0;
      acc_q       <= '0;
      usr_q       <= 1'b0;
      nx_q        <= 1'b0;
      base_q      <= '0;
      fault_code  <= F_NONE;
      fault_level <= '0;
      paddr       <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q        <= req_vaddr;
          acc_q       <= req_acc;
          usr_q       <= req_user;
          nx_q        <= nx_en;
          base_q      <= root_base[PA_W-1:OFF_W];
          lvl         <= '0;
          fault_level <= '0;
          paddr       <= '0;
          if (in_canon) begin
            fault_code <= F_NONE;
            st         <= S_ISSUE;
          end else begin
            fault_code <= F_CANON;
            st         <= S_DONE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (chk != F_NONE) begin
            fault_code  <= chk;
            fault_level <= lvl;
            st          <= S_DONE;
          end else if (lvl == 2'd3) begin
            paddr <= {mem_rdata[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
            st    <= S_DONE;
          end else begin
            base_q <= mem_rdata[PA_W-1:OFF_W];
            lvl    <= lvl + 2'd1;
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  noncanon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_canon) |=> (done && fault_code == F_CANON && !mem_req_valid));
  // R10
  mreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  // R10
  idle_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R3
  pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [39:0] root_base = '0;
  logic        nx_en = 1'b0, req_valid = 1'b0, req_user = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_ready, mem_req_valid, mem_rvalid = 1'b0, done, fault;
  logic [39:0] mem_req_addr, paddr;
  logic [63:0] mem_rdata = '0;
  logic [2:0]  fault_code;
  logic [1:0]  fault_level;

  int checks = 0, fails = 0;
  logic [63:0] mem [logic [39:0]];
  logic [39:0] got_addr [8];
  int n_got = 0;

  always #(CLK_P/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .nx_en(nx_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code),
    .fault_level(fault_level), .paddr(paddr));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [39:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  // independent reference walk
  function automatic void ref_walk(input logic [63:0] va, input logic [1:0] acc,
      input logic usr, input logic nx, input logic [39:0] root,
      output logic [2:0] code, output logic [1:0] lv, output logic [39:0] pa,
      output int nr, output logic [39:0] ea [8]);
    logic [27:0] b;
    logic [63:0] e;
    code = 0; lv = 0; pa = 0; nr = 0;
    for (int i = 0; i < 8; i++) ea[i] = '0;
    if (va[63:47] != {17{va[47]}}) begin code = 1; return; end
    b = root[39:12];
    for (int l = 0; l < 4; l++) begin
      ea[l] = {b, va[47 - 9*l -: 9], 3'b000};
      nr++;
      e = rd(ea[l]);
      lv = 2'(l);
      if (e[0] == 1'b0) begin code = 2; return; end
      if (e[51:40] != 0) begin code = 3; return; end
      if (acc == 2'b01 && !e[1]) begin code = 4; return; end
      if (usr && !e[2]) begin code = 5; return; end
      if (acc == 2'b10 && nx && e[63]) begin code = 6; return; end
      b = e[39:12];
    end
    lv = 0;
    pa = {b, va[11:0]};
  endfunction

  // memory responder, aligned to posedge + 1
  initial begin
    @(posedge clk); #1;
    forever begin
      if (mem_req_valid) begin
        logic [39:0] a;
        int d;
        a = mem_req_addr;
        if (n_got < 8) got_addr[n_got] = a;
        n_got++;
        d = $urandom_range(0, 2);
        for (int k = 0; k <= d; k++) begin
          @(posedge clk); #1;
          if (mem_req_valid) check("R10 second read outstanding", 1, 0);
        end
        mem_rvalid = 1'b1;
        mem_rdata = rd(a);
        @(posedge clk); #1;
        mem_rvalid = 1'b0;
        mem_rdata = $urandom;
      end else begin
        @(posedge clk); #1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R1"; 3'd2: return "R4"; 3'd3: return "R5";
      3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                     input logic nx, input logic poke, input string tag);
    logic [2:0] ec; logic [1:0] el; logic [39:0] ep; int enr;
    logic [39:0] ea [8];
    int cyc;
    ref_walk(va, acc, usr, nx, root_base, ec, el, ep, enr, ea);
    n_got = 0;
    req_vaddr = va; req_acc = acc; req_user = usr; nx_en = nx; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_vaddr = $urandom;
    nx_en = $urandom;
    cyc = 0;
    while (!done) begin
      if (poke && cyc == 1) begin
        req_valid = 1'b1; req_vaddr = 64'h1234_0000_0000_0000; req_acc = 2'b01; req_user = 1'b1;
      end else req_valid = 1'b0;
      if (cyc > 0) check("R11 ready low while busy", req_ready, 0);
      @(posedge clk); #1;
      cyc++;
    end
    req_valid = 1'b0;
    if (ec == 3'd1) check("R1 done right after accept", cyc, 0);
    check({tag, " ", tag_of(ec), " fault_code"}, fault_code, ec);
    check({tag, " ", tag_of(ec), " fault"}, fault, ec != 0);
    if (ec != 0) check({tag, " ", tag_of(ec), " fault_level"}, fault_level, el);
    else check({tag, " R3 paddr"}, paddr, ep);
    check({tag, " R10 read count"}, n_got, enr);
    for (int i = 0; i < 4; i++)
      if (i < enr && i < n_got) check({tag, " R2 entry address"}, got_addr[i], ea[i]);
    @(posedge clk); #1;
    check("R11 done one cycle", done, 0);
    check("R11 ready after done", req_ready, 1);
  endtask

  function automatic logic [63:0] mk_ent(input logic [27:0] b, input logic [63:0] fl);
    return fl | {24'd0, b, 12'd0};
  endfunction

  // chain with frames 0x100+l, flags given per level
  task automatic chain(input logic [63:0] va, input logic [63:0] f0, input logic [63:0] f1,
                       input logic [63:0] f2, input logic [63:0] f3);
    logic [63:0] fl [4];
    logic [27:0] b;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    mem.delete();
    b = root_base[39:12];
    for (int l = 0; l < 4; l++) begin
      mem[{b, va[47 - 9*l -: 9], 3'b000}] = mk_ent(28'h100 + 28'(l), fl[l]);
      b = 28'h100 + 28'(l);
    end
    mem[{b, 12'd0}] = mk_ent(28'h0abcdef, 64'h7);
  endtask

  localparam logic [63:0] OK = 64'h7;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset ready", req_ready, 1);
    check("R11 reset done", done, 0);
    check("R10 reset mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    root_base = 40'h00_0004_2000;

    // directed
    chain(64'h0000_7fff_ffff_f123, OK, OK, OK, OK);
    mem[{28'h103, 9'h1ff, 3'b000}] = mk_ent(28'h0fedcba, OK);
    run(64'h0000_7fff_ffff_f123, 2'b00, 1'b0, 1'b0, 1'b0, "dir low-half");
    chain(64'hffff_8000_0040_2abc, OK, OK, OK, OK);
    mem[{28'h103, 9'h002, 3'b000}] = mk_ent(28'h1234567, OK);
    run(64'hffff_8000_0040_2abc, 2'b01, 1'b1, 1'b1, 1'b0, "dir high-half");
    run(64'hfffe_8000_0040_2abc, 2'b00, 1'b0, 1'b0, 1'b0, "dir one-bit noncanon");
    run(64'h0001_0000_0000_0000, 2'b00, 1'b0, 1'b0, 1'b0, "dir bit48 noncanon");
    for (int l = 0; l < 4; l++) begin
      logic [63:0] f [4];
      for (int j = 0; j < 4; j++) f[j] = (j == l) ? 64'h6 : OK;
      chain(64'h0000_1234_5678_9000, f[0], f[1], f[2], f[3]);
      mem[{28'h103, 9'h189, 3'b000}] = mk_ent(28'h55, OK);
      run(64'h0000_1234_5678_9000, 2'b00, 1'b0, 1'b0, 1'b0, "R4 not-present level");
    end
    chain(64'h0000_0000_0020_1000, OK, OK, 64'h0000_1000_0000_0005, OK);
    run(64'h0000_0000_0020_1000, 2'b01, 1'b0, 1'b0, 1'b0, "R9 reserved over write");
    chain(64'h0000_0000_0020_1000, OK, 64'h0000_1000_0000_0006, OK, OK);
    run(64'h0000_0000_0020_1000, 2'b00, 1'b0, 1'b0, 1'b0, "R9 not-present over reserved");
    chain(64'h0000_0000_0020_1000, OK, 64'h3, OK, OK);
    run(64'h0000_0000_0020_1000, 2'b01, 1'b1, 1'b0, 1'b0, "R7 user fault read ok");
    chain(64'h0000_0000_0020_1000, OK, OK, 64'h5, 64'h1);
    run(64'h0000_0000_0020_1000, 2'b01, 1'b1, 1'b0, 1'b0, "R9 write over user");
    chain(64'h0000_0000_0020_1000, OK, OK, 64'h8000_0000_0000_0007, OK);
    run(64'h0000_0000_0020_1000, 2'b10, 1'b0, 1'b0, 1'b0, "R8 nx disabled");
    run(64'h0000_0000_0020_1000, 2'b10, 1'b0, 1'b1, 1'b0, "R8 nx enabled");
    run(64'h0000_0000_0020_1000, 2'b00, 1'b0, 1'b1, 1'b0, "R8 read ignores xd");
    run(64'h0000_0000_0020_1000, 2'b11, 1'b0, 1'b1, 1'b1, "R11 busy poke");

    // random
    for (int t = 0; t < 400; t++) begin
      logic [63:0] va;
      logic [27:0] b, nb;
      logic [63:0] e;
      va = {$urandom, $urandom};
      if ($urandom_range(0, 9) != 0) va[63:48] = {16{va[47]}};
      root_base = {$urandom_range(0, 255), 12'h000} | 40'h00_1000_0000;
      mem.delete();
      b = root_base[39:12];
      for (int l = 0; l < 4; l++) begin
        nb = 28'($urandom);
        e = {$urandom, $urandom};
        e[51:40] = ($urandom_range(0, 19) == 0) ? 12'($urandom_range(1, 4095)) : 12'd0;
        e[39:12] = nb;
        e[0] = ($urandom_range(0, 9) != 0);
        e[1] = ($urandom_range(0, 4) != 0);
        e[2] = ($urandom_range(0, 4) != 0);
        e[63] = ($urandom_range(0, 6) == 0);
        mem[{b, va[47 - 9*l -: 9], 3'b000}] = e;
        b = nb;
      end
      run(va, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
          1'($urandom_range(0, 3) == 0), "rand");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule